// File: doc/BRIEF.md
# Display Sync Conditioner

This block sits between the raw horizontal and vertical sync inputs of a display monitor and the rest of its timing logic. It resamples both sync inputs on the system clock, decides whether each one is alive, measures each period and works out which level is the active one. The measured periods, polarities and presence bits are held in registers on the output ports, where control software can read them.

Each sync is passed on through an XOR chosen by software, so downstream logic always sees the polarity it expects. When the horizontal input carries composite sync, the block recovers vertical sync from the broad pulses. While that vertical interval lasts, it can replace the broken horizontal pulses with a regenerated train. A clamp pulse with a programmable trigger edge, polarity and width is derived from the normalized horizontal sync. When the horizontal period moves by more than a small tolerance, a sticky flag is raised, and it can be routed to an interrupt.

Top module: `sync_cond_top`

## Requirements
- R1: Both inputs pass through two register stages before use. In separate mode (comp_mode=0), hsync_out equals the resampled horizontal input XOR h_invert, and vsync_out equals the resampled vertical input XOR v_invert.
- R2: h_period holds the number of clock cycles between the last two rising edges of the resampled horizontal sync. It is updated one cycle after the second of those edges, and h_present is set in that same cycle.
- R3: v_period holds the cycle count between rising edges of the vertical source, shifted right by V_DIV_LOG2. The field is 12 bits wide by default. The vertical source is the recovered vertical sync when comp_mode=1 and the resampled vertical input otherwise.
- R4: h_active_high and v_active_high are 1 when twice the number of high cycles in the measured period is less than the period in cycles. In other words, the shorter level is taken as the active one. Otherwise they are 0.
- R5: If a channel sees no rising edge for its timeout (H_TMO or V_TMO cycles), its present, period and polarity outputs all drop to 0. The first rising edge after reset or after a timeout only starts a measurement.
- R6: In composite mode, the normalized horizontal level (resampled input XOR h_invert) is taken as active-high. An active run reaching SEP_TH cycles sets the recovered vertical sync. A falling edge that ends an active run shorter than SEP_TH cycles clears it.
- R7: In composite mode, while the recovered vertical sync is high and ins_disable=0, hsync_out carries inserted pulses. Each pulse is INS_W cycles wide and repeats every h_period cycles, starting in the first cycle of the interval. If h_period is below 2, hsync_out stays low.
- R8: With ins_disable=1, hsync_out always follows the normalized horizontal level, whatever the recovered vertical sync is doing.
- R9: The clamp pulse starts one cycle after a trigger edge of the normalized horizontal level. The edge is rising for clamp_trail=0 and falling for clamp_trail=1. The pulse lasts (clamp_width+1)·2^CLP_SHIFT cycles, and a new trigger restarts it.
- R10: clamp_out is active-high when clamp_low=0 and inverted when clamp_low=1.
- R11: When a new h_period differs from the previous one by more than FCHG_TOL counts while the channel stays present, hchg_flag is set in the next cycle. The first measurement after presence is gained never sets it.
- R12: hchg_flag stays set until a cycle with hchg_clr=1 clears it.
- R13: irq equals hchg_flag AND hchg_ie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal or composite sync input |
| vsync_in | input | 1 | Vertical sync input |
| comp_mode | input | 1 | 1: hsync_in carries composite sync |
| h_invert | input | 1 | XOR applied to horizontal sync |
| v_invert | input | 1 | XOR applied to vertical sync in separate mode |
| ins_disable | input | 1 | 1: no pulse insertion during recovered vertical sync |
| clamp_trail | input | 1 | Clamp trigger edge: 0 rising, 1 falling |
| clamp_low | input | 1 | 1: clamp_out active-low |
| clamp_width | input | 3 | Clamp width code |
| hchg_ie | input | 1 | Enable of the frequency-change interrupt |
| hchg_clr | input | 1 | Clears hchg_flag |
| hsync_out | output | 1 | Conditioned horizontal sync |
| vsync_out | output | 1 | Conditioned or recovered vertical sync |
| clamp_out | output | 1 | Clamp pulse |
| h_period | output | H_CNT_W | Horizontal period in clock cycles |
| h_active_high | output | 1 | Horizontal sync measured active-high |
| h_present | output | 1 | Horizontal sync present |
| v_period | output | V_CNT_W | Vertical period in 2^V_DIV_LOG2-cycle units |
| v_active_high | output | 1 | Vertical source measured active-high |
| v_present | output | 1 | Vertical source present |
| hchg_flag | output | 1 | Sticky horizontal frequency-change flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The assertions check on every cycle that an absent channel shows zero period and polarity. They also check that a present horizontal channel never reports a zero period, that a vertical update only coincides with presence, that the change flag is sticky, and that gaining presence never raises the flag. Other behaviours can only be shown by the bench's scenarios against its reference model: the exact period counts at both prescales, polarity choice for both input senses, the timeout, composite separation with and without insertion, clamp edge, width and polarity, and the 2-count tolerance boundary.

// File: rtl/sync_pkg.sv
package sync_pkg;
  typedef enum logic {CLP_LEAD = 1'b0, CLP_TRAIL = 1'b1} clp_edge_e;
  localparam int CLP_FIELD_W = 3;
endpackage

// File: rtl/sync_period_meas.sv
// Period, polarity and presence measurement of one resampled sync line.
module sync_period_meas #(
  parameter int CNT_W    = 12,
  parameter int DIV_LOG2 = 0,
  parameter int TMO      = 4000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig,
  output logic [CNT_W-1:0] period,
  output logic             active_high,
  output logic             present,
  output logic             upd
);
  localparam int CYC_W = CNT_W + DIV_LOG2;
  localparam logic [CYC_W-1:0] CYC_MAX = '1;
  localparam logic [CYC_W-1:0] TMO_M1  = CYC_W'(TMO - 1);

  logic             sig_d;
  logic             armed;
  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] hi;
  logic             rise;
  logic             tmo;

  assign rise = sig & ~sig_d;
  assign tmo  = ~rise & (cyc >= TMO_M1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_d       <= 1'b0;
      armed       <= 1'b0;
      cyc         <= '0;
      hi          <= '0;
      period      <= '0;
      active_high <= 1'b0;
      present     <= 1'b0;
      upd         <= 1'b0;
    end else begin
      sig_d <= sig;
      upd   <= 1'b0;
      if (rise) begin
        if (armed) begin
          period      <= cyc[CYC_W-1:DIV_LOG2];
          active_high <= ({hi, 1'b0} < {1'b0, cyc});
          present     <= 1'b1;
          upd         <= 1'b1;
        end
        armed <= 1'b1;
        cyc   <= CYC_W'(1);
        hi    <= CYC_W'(1);
      end else begin
        if (cyc != CYC_MAX) cyc <= cyc + 1'b1;
        if (sig && (hi != CYC_MAX)) hi <= hi + 1'b1;
        if (tmo) begin
          armed       <= 1'b0;
          present     <= 1'b0;
          period      <= '0;
          active_high <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/csync_sep.sv
// Vertical sync recovery from composite sync and horizontal pulse insertion.
module csync_sep #(
  parameter int SEP_TH = 24,
  parameter int CNT_W  = 12,
  parameter int INS_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hn,
  input  logic             comp,
  input  logic             ins_dis,
  input  logic [CNT_W-1:0] hper,
  output logic             vsep,
  output logic             h_out
);
  localparam int RUN_W = $clog2(SEP_TH + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] SET_AT  = RUN_W'(SEP_TH - 1);
  localparam logic [RUN_W-1:0] TH_V    = RUN_W'(SEP_TH);
  localparam logic [CNT_W-1:0] INS_LIM = CNT_W'(INS_W);
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

  logic             hn_d;
  logic [RUN_W-1:0] run;
  logic [CNT_W-1:0] icnt;
  logic [CNT_W:0]   icnt_p1;
  logic             ins_on;
  logic             wrap;
  logic             gen;

  assign ins_on  = comp & vsep & ~ins_dis;
  assign icnt_p1 = {1'b0, icnt} + 1'b1;
  assign wrap    = icnt_p1 >= {1'b0, hper};
  assign gen     = ins_on && (hper >= MIN_PER) && (icnt < INS_LIM);
  assign h_out   = ins_on ? gen : hn;

  always_ff @(posedge clk) begin
    if (rst) begin
      hn_d <= 1'b0;
      run  <= '0;
      vsep <= 1'b0;
      icnt <= '0;
    end else begin
      hn_d <= hn;
      if (hn) begin
        if (run != RUN_MAX) run <= run + 1'b1;
      end else begin
        run <= '0;
      end
      if (hn && (run == SET_AT)) vsep <= 1'b1;
      else if (!hn && hn_d && (run < TH_V)) vsep <= 1'b0;
      if (!ins_on || wrap) icnt <= '0;
      else icnt <= icnt + 1'b1;
    end
  end
endmodule

// File: rtl/clamp_gen.sv
// Clamp pulse with selectable trigger edge, polarity and width.
module clamp_gen
  import sync_pkg::*;
#(
  parameter int SHIFT = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hn,
  input  clp_edge_e              edge_sel,
  input  logic [CLP_FIELD_W-1:0] width,
  input  logic                   pol_low,
  output logic                   clamp_out
);
  localparam int CW = CLP_FIELD_W + 1 + SHIFT;

  logic               hn_d;
  logic [CW-1:0]      cnt;
  logic [CLP_FIELD_W:0] wp1;
  logic [CW-1:0]      load;
  logic               trig;

  assign wp1  = {1'b0, width} + 1'b1;
  assign load = CW'(wp1) << SHIFT;
  assign trig = (edge_sel == CLP_TRAIL) ? (~hn & hn_d) : (hn & ~hn_d);
  assign clamp_out = (cnt != '0) ^ pol_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      hn_d <= 1'b0;
      cnt  <= '0;
    end else begin
      hn_d <= hn;
      if (trig) cnt <= load;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sync_cond_top.sv
module sync_cond_top #(
  parameter int H_CNT_W    = 12,
  parameter int V_CNT_W    = 12,
  parameter int V_DIV_LOG2 = 4,
  parameter int H_TMO      = 4000,
  parameter int V_TMO      = 60000,
  parameter int SEP_TH     = 24,
  parameter int INS_W      = 8,
  parameter int CLP_SHIFT  = 1,
  parameter int FCHG_TOL   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic               comp_mode,
  input  logic               h_invert,
  input  logic               v_invert,
  input  logic               ins_disable,
  input  logic               clamp_trail,
  input  logic               clamp_low,
  input  logic [2:0]         clamp_width,
  input  logic               hchg_ie,
  input  logic               hchg_clr,
  output logic               hsync_out,
  output logic               vsync_out,
  output logic               clamp_out,
  output logic [H_CNT_W-1:0] h_period,
  output logic               h_active_high,
  output logic               h_present,
  output logic [V_CNT_W-1:0] v_period,
  output logic               v_active_high,
  output logic               v_present,
  output logic               hchg_flag,
  output logic               irq
);
  localparam int NSYNC = 2;
  localparam logic [H_CNT_W-1:0] TOL_V = H_CNT_W'(FCHG_TOL);

  logic [NSYNC-1:0] pin_vec, st1, st2;
  logic             h_norm, vsep, v_src, h_upd, v_upd;
  logic [H_CNT_W-1:0] last_per, dlt;
  logic             last_ok, big;

  assign pin_vec = {vsync_in, hsync_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      st1 <= '0;
      st2 <= '0;
    end else begin
      st1 <= pin_vec;
      st2 <= st1;
    end
  end

  assign h_norm    = st2[0] ^ h_invert;
  assign v_src     = comp_mode ? vsep : st2[1];
  assign vsync_out = comp_mode ? vsep : (st2[1] ^ v_invert);

  sync_period_meas #(.CNT_W(H_CNT_W), .DIV_LOG2(0), .TMO(H_TMO)) u_hmeas (
    .clk(clk), .rst(rst), .sig(st2[0]), .period(h_period),
    .active_high(h_active_high), .present(h_present), .upd(h_upd)
  );

  sync_period_meas #(.CNT_W(V_CNT_W), .DIV_LOG2(V_DIV_LOG2), .TMO(V_TMO)) u_vmeas (
    .clk(clk), .rst(rst), .sig(v_src), .period(v_period),
    .active_high(v_active_high), .present(v_present), .upd(v_upd)
  );

  csync_sep #(.SEP_TH(SEP_TH), .CNT_W(H_CNT_W), .INS_W(INS_W)) u_sep (
    .clk(clk), .rst(rst), .hn(h_norm), .comp(comp_mode), .ins_dis(ins_disable),
    .hper(h_period), .vsep(vsep), .h_out(hsync_out)
  );

  clamp_gen #(.SHIFT(CLP_SHIFT)) u_clamp (
    .clk(clk), .rst(rst), .hn(h_norm),
    .edge_sel(sync_pkg::clp_edge_e'(clamp_trail)),
    .width(clamp_width), .pol_low(clamp_low), .clamp_out(clamp_out)
  );

  assign dlt = (h_period >= last_per) ? (h_period - last_per) : (last_per - h_period);
  assign big = last_ok && (dlt > TOL_V);
  assign irq = hchg_flag & hchg_ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_per  <= '0;
      last_ok   <= 1'b0;
      hchg_flag <= 1'b0;
    end else begin
      if (h_upd) begin
        last_per <= h_period;
        last_ok  <= 1'b1;
      end else if (!h_present) begin
        last_ok <= 1'b0;
      end
      if (h_upd && big) hchg_flag <= 1'b1;
      else if (hchg_clr) hchg_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_cond_chk.sv
module sync_cond_chk #(
  parameter int H_CNT_W = 12,
  parameter int V_CNT_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [H_CNT_W-1:0] h_period,
  input logic               h_present,
  input logic               h_active_high,
  input logic [V_CNT_W-1:0] v_period,
  input logic               v_present,
  input logic               v_active_high,
  input logic               v_upd,
  input logic               hchg_flag,
  input logic               hchg_clr
);
  a_r5_h_absent_clear: assert property (@(posedge clk) disable iff (rst)
    !h_present |-> (h_period == '0 && !h_active_high));

  a_r5_v_absent_clear: assert property (@(posedge clk) disable iff (rst)
    !v_present |-> (v_period == '0 && !v_active_high));

  a_r2_h_period_nonzero: assert property (@(posedge clk) disable iff (rst)
    h_present |-> (h_period != '0));

  a_r3_v_upd_present: assert property (@(posedge clk) disable iff (rst)
    v_upd |-> v_present);

  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (hchg_flag && !hchg_clr) |=> hchg_flag);

  a_r11_first_no_flag: assert property (@(posedge clk) disable iff (rst)
    ($rose(h_present) && !hchg_flag) |=> !hchg_flag);
endmodule

bind sync_cond_top sync_cond_chk #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W)) u_chk (
  .clk(clk), .rst(rst), .h_period(h_period), .h_present(h_present),
  .h_active_high(h_active_high), .v_period(v_period), .v_present(v_present),
  .v_active_high(v_active_high), .v_upd(v_upd), .hchg_flag(hchg_flag),
  .hchg_clr(hchg_clr)
);

// File: tb/sync_cond_top_tb.sv
module sync_cond_top_tb;
  localparam int HW = 12, VW = 12, VL = 2, HT = 600, VT = 6000;
  localparam int STH = 20, IW = 4, CS = 1, TOL = 2;
  localparam int RUN_MAX = (1 << $clog2(STH + 1)) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic hsync_in = 0, vsync_in = 0, comp_mode = 0, h_invert = 0, v_invert = 0;
  logic ins_disable = 0, clamp_trail = 0, clamp_low = 0, hchg_ie = 0, hchg_clr = 0;
  logic [2:0] clamp_width = 3'd2;
  logic hsync_out, vsync_out, clamp_out, h_active_high, h_present;
  logic v_active_high, v_present, hchg_flag, irq;
  logic [HW-1:0] h_period;
  logic [VW-1:0] v_period;

  always #4 clk = ~clk;

  sync_cond_top #(.H_CNT_W(HW), .V_CNT_W(VW), .V_DIV_LOG2(VL), .H_TMO(HT),
    .V_TMO(VT), .SEP_TH(STH), .INS_W(IW), .CLP_SHIFT(CS), .FCHG_TOL(TOL)) u_dut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .comp_mode(comp_mode), .h_invert(h_invert), .v_invert(v_invert),
    .ins_disable(ins_disable), .clamp_trail(clamp_trail), .clamp_low(clamp_low),
    .clamp_width(clamp_width), .hchg_ie(hchg_ie), .hchg_clr(hchg_clr),
    .hsync_out(hsync_out), .vsync_out(vsync_out), .clamp_out(clamp_out),
    .h_period(h_period), .h_active_high(h_active_high), .h_present(h_present),
    .v_period(v_period), .v_active_high(v_active_high), .v_present(v_present),
    .hchg_flag(hchg_flag), .irq(irq));

  int vec = 0, mis = 0;
  bit started = 0, done = 0;

  // ---------------- reference model ----------------
  int m_s1h, m_sh, m_s1v, m_sv;
  int m_sp[2], m_cyc[2], m_hi[2], m_arm[2], m_pres[2], m_per[2], m_pol[2], m_upd[2];
  int m_hnd, m_run, m_vsep, m_icnt, m_cnd, m_ccnt, m_last, m_lok, m_flag;
  int tmo_of[2] = '{HT, VT};
  int shf[2]    = '{0, VL};
  int cmax[2]   = '{(1 << HW) - 1, (1 << (VW + VL)) - 1};

  task automatic step_ch(input int ch, input int sig);
    bit rise = (sig != 0) && (m_sp[ch] == 0);
    bit tmo  = !rise && (m_cyc[ch] >= tmo_of[ch] - 1);
    m_upd[ch] = 0;
    if (rise) begin
      if (m_arm[ch] != 0) begin
        m_per[ch]  = m_cyc[ch] >> shf[ch];
        m_pol[ch]  = (2 * m_hi[ch] < m_cyc[ch]) ? 1 : 0;
        m_pres[ch] = 1;
        m_upd[ch]  = 1;
      end
      m_arm[ch] = 1; m_cyc[ch] = 1; m_hi[ch] = 1;
    end else begin
      if (m_cyc[ch] < cmax[ch]) m_cyc[ch]++;
      if (sig != 0 && m_hi[ch] < cmax[ch]) m_hi[ch]++;
      if (tmo) begin m_arm[ch] = 0; m_pres[ch] = 0; m_per[ch] = 0; m_pol[ch] = 0; end
    end
    m_sp[ch] = sig;
  endtask

  always @(posedge clk) begin
    int hn, vsrc, ins_on, trig, dif;
    started = 1;
    if (rst) begin
      m_s1h = 0; m_sh = 0; m_s1v = 0; m_sv = 0;
      for (int c = 0; c < 2; c++) begin
        m_sp[c] = 0; m_cyc[c] = 0; m_hi[c] = 0; m_arm[c] = 0;
        m_pres[c] = 0; m_per[c] = 0; m_pol[c] = 0; m_upd[c] = 0;
      end
      m_hnd = 0; m_run = 0; m_vsep = 0; m_icnt = 0; m_cnd = 0; m_ccnt = 0;
      m_last = 0; m_lok = 0; m_flag = 0;
    end else begin
      hn   = m_sh ^ int'(h_invert);
      vsrc = comp_mode ? m_vsep : m_sv;
      // R11/R12 frequency change
      if (m_upd[0] != 0) begin
        dif = m_per[0] - m_last;
        if (dif < 0) dif = -dif;
        if (m_lok != 0 && dif > TOL) m_flag = 1;
        else if (hchg_clr) m_flag = 0;
        m_last = m_per[0]; m_lok = 1;
      end else begin
        if (m_pres[0] == 0) m_lok = 0;
        if (hchg_clr) m_flag = 0;
      end
      // R7 insertion counter
      ins_on = (comp_mode && m_vsep != 0 && !ins_disable) ? 1 : 0;
      if (ins_on == 0 || m_icnt + 1 >= m_per[0]) m_icnt = 0; else m_icnt++;
      // R9 clamp
      trig = clamp_trail ? (hn == 0 && m_cnd != 0) : (hn != 0 && m_cnd == 0);
      m_cnd = hn;
      if (trig != 0) m_ccnt = (int'(clamp_width) + 1) << CS;
      else if (m_ccnt > 0) m_ccnt--;
      // R6 separation
      if (hn != 0 && m_run == STH - 1) m_vsep = 1;
      else if (hn == 0 && m_hnd != 0 && m_run < STH) m_vsep = 0;
      m_run = (hn != 0) ? ((m_run < RUN_MAX) ? m_run + 1 : m_run) : 0;
      m_hnd = hn;
      step_ch(0, m_sh);
      step_ch(1, vsrc);
      m_sv = m_s1v; m_s1v = int'(vsync_in);
      m_sh = m_s1h; m_s1h = int'(hsync_in);
    end
  end

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    if (act != exp) begin
      mis++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, nm, $time, act, exp);
    end
  endtask

  // ---------------- stimulus generator state ----------------
  int g_hon = 0, g_von = 0, g_comp = 0, g_hneg = 0, g_vneg = 0;
  int g_hp = 100, g_hw = 10, g_vp = 20, g_vw = 2;
  int hc = 0, vl = 0;

  always @(negedge clk) begin
    int hn_now, ins_now, gen, hact, vact;
    if (started) begin
      vec++;
      hn_now  = m_sh ^ int'(h_invert);
      ins_now = (comp_mode && m_vsep != 0 && !ins_disable) ? 1 : 0;
      gen     = (ins_now != 0 && m_per[0] >= 2 && m_icnt < IW) ? 1 : 0;
      chk("R1/R7/R8", "hsync_out", int'(hsync_out), (ins_now != 0) ? gen : hn_now);
      chk("R1/R6", "vsync_out", int'(vsync_out), comp_mode ? m_vsep : (m_sv ^ int'(v_invert)));
      chk("R2/R5", "h_period", int'(h_period), m_per[0]);
      chk("R3", "v_period", int'(v_period), m_per[1]);
      chk("R4", "h_active_high", int'(h_active_high), m_pol[0]);
      chk("R4", "v_active_high", int'(v_active_high), m_pol[1]);
      chk("R5", "h_present", int'(h_present), m_pres[0]);
      chk("R5", "v_present", int'(v_present), m_pres[1]);
      chk("R11/R12", "hchg_flag", int'(hchg_flag), m_flag);
      chk("R13", "irq", int'(irq), (m_flag != 0 && hchg_ie) ? 1 : 0);
      chk("R9/R10", "clamp_out", int'(clamp_out), ((m_ccnt != 0) ? 1 : 0) ^ int'(clamp_low));
    end
    if (g_hon != 0) begin
      hc++;
      if (hc >= g_hp) begin
        hc = 0; vl++;
        if (vl >= g_vp) vl = 0;
      end
    end
    hact = (hc < g_hw) ? 1 : 0;
    vact = (vl < g_vw) ? 1 : 0;
    if (g_hon == 0) hsync_in = 1'b0;
    else if (g_comp != 0) hsync_in = 1'(((vact != 0) ? ((hc < g_hp - g_hw) ? 1 : 0) : hact) ^ g_hneg);
    else hsync_in = 1'(hact ^ g_hneg);
    vsync_in = (g_von != 0 && g_comp == 0 && g_hon != 0) ? 1'(vact ^ g_vneg) : 1'b0;
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_clr();
    hchg_clr = 1'b1; run(1); hchg_clr = 1'b0;
  endtask

  initial begin
    run(5);
    rst = 1'b0;
    run(60);                               // R5 idle reset state
    g_hon = 1; g_von = 1; run(4500);       // R2 R3 R4 active-high syncs
    g_hneg = 1; g_vneg = 1; h_invert = 1; v_invert = 1; hchg_ie = 1;
    run(4500);                             // R1 R4 active-low syncs
    pulse_clr();                           // R12
    g_hneg = 0; g_vneg = 0; h_invert = 0; v_invert = 0;
    run(600); pulse_clr();
    g_hp = 102; run(700);                  // R11 difference of 2: no flag
    g_hp = 105; run(700);                  // R11 difference of 3: flag, R13 irq
    hchg_ie = 0; run(50);                  // R13 gated
    pulse_clr(); hchg_ie = 1; run(20);     // R12 clear
    g_hp = 100;
    clamp_trail = 1; clamp_low = 1; clamp_width = 3'd5; run(400);   // R9 R10
    clamp_trail = 0; clamp_width = 3'd0; run(300);
    clamp_low = 0; clamp_width = 3'd7; run(300);
    g_hon = 0; g_von = 0; run(6500);       // R5 timeout on both
    pulse_clr();
    g_hon = 1; g_comp = 1; comp_mode = 1; run(5000);   // R6 R7
    ins_disable = 1; run(2500);            // R8
    ins_disable = 0; comp_mode = 0; g_comp = 0; g_von = 1; run(3000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mis++;
      $display("FAIL watchdog: actual run still going, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  end
endmodule